// File: doc/BRIEF.md
# External Bus Line Burst Controller

This block is a bus master that moves one 16-byte cache line, four 32-bit longwords, between an internal requester and a synchronous external bus. The requester presents a line address, a direction and, for writes, the whole 128-bit line. The block then runs the external handshake: an address clock marked by a start strobe, followed by data clocks that each end when the slave returns a transfer acknowledge. For reads, the four returned longwords are gathered into a 128-bit line. A one-clock done pulse marks the end of the line.

Two transfer shapes can be chosen for each request. In burst mode, one address clock is followed by four data beats. After the first beat, each beat takes a single clock when the slave adds no wait states. In burst-inhibited mode, the line is split into four separate longword cycles, and each cycle has its own address clock. Chip select stays asserted from the first address clock until the last acknowledge in both modes. A per-request termination flag controls the address outputs. With external termination, the longword-select address bits follow the beat. With internal termination in burst mode, the address stays at the line base.

Top module: `ebl_line_ctrl`

## Requirements
- R1: A request is taken only when `xfer_busy_o` is low. A request raised while a line is in flight has no effect. Address bits [3:0] of a request are ignored, so every line starts on a 16-byte boundary.
- R2: `xfer_start_o` is a one-clock pulse. In burst mode it appears once per line. In burst-inhibited mode it appears at the start of each of the four longword cycles. `xfer_busy_o` rises together with the first start pulse and stays high through the clock in which the final acknowledge is sampled.
- R3: `cs_o` stays high without a gap from the first address clock to the clock of the final acknowledge. It drops only when the line completes.
- R4: A beat completes only on a clock edge where `ta_i` is high during a data clock. `ta_i` during an address clock or while idle is ignored. A data clock without acknowledge is a wait state, and the address and write data are held through it.
- R5: Beats run in the order 0, 1, 2, 3. With external termination, or in burst-inhibited mode, `bus_addr_o[3:2]` equals the beat number during each data clock. With internal termination in burst mode, `bus_addr_o` stays at the line base (bits [3:2] = 00) for the whole line.
- R6: During a transfer, `bus_size_o` is `SIZE_LINE` (default 2'b11) in burst mode and `SIZE_LONG` (default 2'b00) in burst-inhibited mode.
- R7: On a write, data is driven (`data_oe_o` high) starting in the clock after the start pulse. During beat k, `data_o` equals bits [32k+31:32k] of the request line. `byte_en_o` is 4'b1111 on every write data clock, and `out_en_o` stays low.
- R8: On a read, `out_en_o` is high in data clocks only and `rd_nwr_o` is high. Bits [32k+31:32k] of `rline_o` take the value of `data_i` sampled at the k-th acknowledge.
- R9: With zero wait states, a burst line occupies 5 busy clocks and a burst-inhibited line occupies 8. With one wait state per beat, a burst line follows a 3-2-2-2 pattern, 9 busy clocks in total.
- R10: `done_o` is a one-clock pulse in the clock after the final acknowledge, with `xfer_busy_o` already low. `rline_o` then holds the read line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Line request, sampled while idle |
| req_we_i | input | 1 | 1 = write line, 0 = read line |
| req_burst_i | input | 1 | 1 = burst, 0 = four separate longword cycles |
| req_ext_term_i | input | 1 | 1 = external termination (address follows beat) |
| req_addr_i | input | AW | Line address, low four bits ignored |
| req_wline_i | input | 128 | Write line, longword k in bits [32k+31:32k] |
| done_o | output | 1 | Line complete pulse |
| rline_o | output | 128 | Read line |
| bus_addr_o | output | AW | External address |
| bus_size_o | output | SW | Transfer size code |
| xfer_start_o | output | 1 | Transfer start strobe |
| xfer_busy_o | output | 1 | Transfer in progress |
| rd_nwr_o | output | 1 | 1 = read cycle |
| cs_o | output | 1 | Chip select |
| byte_en_o | output | 4 | Byte strobes |
| out_en_o | output | 1 | Output enable for the slave |
| data_oe_o | output | 1 | Write data drive enable |
| data_o | output | 32 | Write data |
| data_i | input | 32 | Read data |
| ta_i | input | 1 | Transfer acknowledge |

## Verification
The checker watches the cycle-local rules on every clock: the start pulse is one clock wide and opens each transfer, chip select falls only together with done, address and write data hold across wait states, byte strobes stay confined to write clocks and output enable to read clocks, and done is a single clock that follows an acknowledge. The bench scenarios cover the rules that span a whole line. These are the beat order and the address that follows each beat under each termination mode, the size code for each mode, and the lane placement of write and read data. They also include the total clock counts for several wait-state settings, the acknowledges that must be ignored, and a request raised while a line is in flight.

// File: rtl/ebl_pkg.sv
package ebl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } ebl_state_e;
endpackage

// File: rtl/ebl_beat_ctr.sv
module ebl_beat_ctr #(
  parameter int BEATS = 4,
  localparam int BW = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [BW-1:0] beat_o,
  output logic          last_o
);
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_q <= '0;
    else if (clr_i)  beat_q <= '0;
    else if (adv_i)  beat_q <= beat_q + BW'(1);
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == BW'(BEATS - 1));
endmodule

// File: rtl/ebl_addr_gen.sv
module ebl_addr_gen #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int BW       = $clog2(BEATS),
  localparam int BYTE_OFF = $clog2(DW / 8),
  localparam int LINE_OFF = BYTE_OFF + BW
) (
  input  logic [AW-1:0] base_i,
  input  logic [BW-1:0] beat_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LINE_MASK = AW'((64'd1 << LINE_OFF) - 64'd1);

  logic [AW-1:0] off;

  assign off    = {{(AW - LINE_OFF){1'b0}}, beat_i, {BYTE_OFF{1'b0}}};
  assign addr_o = (base_i & ~LINE_MASK) | (adv_i ? off : '0);
endmodule

// File: rtl/ebl_line_buf.sv
module ebl_line_buf #(
  parameter int DW    = 32,
  parameter int BEATS = 4,
  localparam int BW = $clog2(BEATS),
  localparam int LW = DW * BEATS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [LW-1:0] wline_i,
  input  logic [BW-1:0] beat_i,
  input  logic          cap_i,
  input  logic [DW-1:0] rword_i,
  output logic [DW-1:0] wword_o,
  output logic [LW-1:0] rline_o
);
  logic [LW-1:0] wline_q;
  logic [DW-1:0] rlane_q [BEATS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wline_q <= '0;
    else if (load_i) wline_q <= wline_i;
  end

  assign wword_o = wline_q[beat_i*DW +: DW];

  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           rlane_q[g] <= '0;
      else if (cap_i && beat_i == BW'(g))    rlane_q[g] <= rword_i;
    end
    assign rline_o[g*DW +: DW] = rlane_q[g];
  end
endmodule

// File: rtl/ebl_line_ctrl.sv
module ebl_line_ctrl #(
  parameter int             AW        = 32,
  parameter int             DW        = 32,
  parameter int             BEATS     = 4,
  parameter int             SW        = 2,
  parameter logic [SW-1:0]  SIZE_LINE = 2'b11,
  parameter logic [SW-1:0]  SIZE_LONG = 2'b00,
  localparam int            BW        = $clog2(BEATS),
  localparam int            LW        = DW * BEATS,
  localparam int            BEW       = DW / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           req_we_i,
  input  logic           req_burst_i,
  input  logic           req_ext_term_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [LW-1:0]  req_wline_i,
  output logic           done_o,
  output logic [LW-1:0]  rline_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [SW-1:0]  bus_size_o,
  output logic           xfer_start_o,
  output logic           xfer_busy_o,
  output logic           rd_nwr_o,
  output logic           cs_o,
  output logic [BEW-1:0] byte_en_o,
  output logic           out_en_o,
  output logic           data_oe_o,
  output logic [DW-1:0]  data_o,
  input  logic [DW-1:0]  data_i,
  input  logic           ta_i
);
  import ebl_pkg::*;

  ebl_state_e    state_q, state_d;
  logic          we_q, burst_q, ext_q, done_q;
  logic [AW-1:0] base_q;
  logic          accept, in_data, ack, last, beat_adv;
  logic [BW-1:0] beat;
  logic [AW-1:0] gen_addr;
  logic [DW-1:0] wword;

  assign accept   = (state_q == ST_IDLE) && req_i;
  assign in_data  = (state_q == ST_DATA);
  assign ack      = in_data && ta_i;
  assign beat_adv = ack && !last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (ta_i) begin
          if (last)         state_d = ST_IDLE;
          else if (!burst_q) state_d = ST_ADDR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      burst_q <= 1'b0;
      ext_q   <= 1'b0;
      base_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ack && last;
      if (accept) begin
        we_q    <= req_we_i;
        burst_q <= req_burst_i;
        ext_q   <= req_ext_term_i;
        base_q  <= req_addr_i;
      end
    end
  end

  ebl_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .adv_i  (beat_adv),
    .beat_o (beat),
    .last_o (last)
  );

  // inhibited cycles are separate longword accesses, so their address always steps
  ebl_addr_gen #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_addr (
    .base_i (base_q),
    .beat_i (beat),
    .adv_i  (ext_q || !burst_q),
    .addr_o (gen_addr)
  );

  ebl_line_buf #(.DW(DW), .BEATS(BEATS)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .wline_i (req_wline_i),
    .beat_i  (beat),
    .cap_i   (ack && !we_q),
    .rword_i (data_i),
    .wword_o (wword),
    .rline_o (rline_o)
  );

  assign xfer_busy_o  = (state_q != ST_IDLE);
  assign xfer_start_o = (state_q == ST_ADDR);
  assign cs_o         = xfer_busy_o;
  assign rd_nwr_o     = xfer_busy_o && !we_q;
  assign out_en_o     = in_data && !we_q;
  assign data_oe_o    = in_data && we_q;
  assign byte_en_o    = data_oe_o ? '1 : '0;
  assign data_o       = data_oe_o ? wword : '0;
  assign bus_addr_o   = xfer_busy_o ? gen_addr : '0;
  assign bus_size_o   = !xfer_busy_o ? '0 : (burst_q ? SIZE_LINE : SIZE_LONG);
  assign done_o       = done_q;
endmodule

// File: rtl/ebl_line_ctrl_chk.sv
module ebl_line_ctrl_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int BEW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           xfer_start_o,
  input logic           xfer_busy_o,
  input logic           cs_o,
  input logic           rd_nwr_o,
  input logic           out_en_o,
  input logic           data_oe_o,
  input logic [BEW-1:0] byte_en_o,
  input logic [AW-1:0]  bus_addr_o,
  input logic [DW-1:0]  data_o,
  input logic           ta_i,
  input logic           done_o
);
  a_r2_start_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |=> !xfer_start_o);

  a_r2_busy_opens_with_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_busy_o) |-> xfer_start_o);

  a_r3_cs_drops_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o);

  a_r4_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_busy_o && !xfer_start_o && !ta_i) |=>
      (xfer_busy_o && !xfer_start_o && $stable(bus_addr_o) && $stable(data_o)));

  a_r7_strobes_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (byte_en_o == '1 && !out_en_o));

  a_r8_oe_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_en_o |-> (rd_nwr_o && !data_oe_o));

  a_r10_done_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_follows_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(ta_i) && !xfer_busy_o));
endmodule

bind ebl_line_ctrl ebl_line_ctrl_chk #(.AW(AW), .DW(DW), .BEW(BEW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xfer_start_o (xfer_start_o),
  .xfer_busy_o  (xfer_busy_o),
  .cs_o         (cs_o),
  .rd_nwr_o     (rd_nwr_o),
  .out_en_o     (out_en_o),
  .data_oe_o    (data_oe_o),
  .byte_en_o    (byte_en_o),
  .bus_addr_o   (bus_addr_o),
  .data_o       (data_o),
  .ta_i         (ta_i),
  .done_o       (done_o)
);

// File: tb/ebl_line_ctrl_tb.sv
`timescale 1ns/1ps
module ebl_line_ctrl_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0, req_we_i = 1'b0, req_burst_i = 1'b0, req_ext_term_i = 1'b0;
  logic [31:0]  req_addr_i = '0;
  logic [127:0] req_wline_i = '0;
  logic         done_o;
  logic [127:0] rline_o;
  logic [31:0]  bus_addr_o;
  logic [1:0]   bus_size_o;
  logic         xfer_start_o, xfer_busy_o, rd_nwr_o, cs_o, out_en_o, data_oe_o;
  logic [3:0]   byte_en_o;
  logic [31:0]  data_o;
  logic [31:0]  data_i = '0;
  logic         ta_i = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  ebl_line_ctrl u_dut (.*);

  // {we, burst, ext, wait[1:0], early_ta, busy_clocks[4:0], start_pulses[2:0]}
  localparam int NV = 8;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 5'd5,  3'd1},
    {1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 5'd9,  3'd1},
    {1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 5'd5,  3'd1},
    {1'b1, 1'b1, 1'b1, 2'd2, 1'b0, 5'd13, 3'd1},
    {1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 5'd8,  3'd4},
    {1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 5'd12, 3'd4},
    {1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 5'd5,  3'd1},
    {1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 5'd8,  3'd4}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_line(input int idx, input logic we, input logic burst, input logic ext,
                          input int wt, input logic early, input int exp_cyc, input int exp_ts,
                          input bit inject);
    logic [31:0]  base = 32'h1000_0000 + 32'(idx) * 32'h40 + 32'h7;
    logic [127:0] wl, rl;
    logic [31:0]  exp_addr;
    int cyc = 0, tsc = 0, bidx = 0, wcnt = 0, guard = 0;
    bit adv;
    for (int b = 0; b < 4; b++) begin
      wl[b*32 +: 32] = 32'hC0DE_0000 | (32'(idx) << 8) | 32'(b);
      rl[b*32 +: 32] = 32'hA500_0000 | (32'(idx) << 8) | 32'(b);
    end
    @(negedge clk_i);
    req_i = 1'b1; req_we_i = we; req_burst_i = burst; req_ext_term_i = ext;
    req_addr_i = base; req_wline_i = wl;
    @(negedge clk_i);
    req_i = 1'b0; req_addr_i = '0; req_wline_i = '0;
    while (!done_o && guard < 200) begin
      guard++;
      adv = 1'b0;
      if (xfer_busy_o) cyc++;
      if (xfer_start_o) begin
        tsc++;
        ta_i = early;          // R4: acknowledge in an address clock must be ignored
        data_i = 32'hDEAD_BEEF;
        wcnt = 0;
      end else if (xfer_busy_o) begin
        exp_addr = (base & ~32'hF) | ((ext || !burst) ? (32'(bidx) << 2) : 32'h0);
        chk(bus_addr_o == exp_addr, "R5", "address", bus_addr_o, exp_addr);
        chk(bus_size_o == (burst ? 2'b11 : 2'b00), "R6", "size", bus_size_o, burst ? 2'b11 : 2'b00);
        chk(cs_o, "R3", "cs held", cs_o, 1);
        chk(rd_nwr_o == !we, "R8", "rd_nwr", rd_nwr_o, !we);
        chk(out_en_o == !we, "R8", "out_en", out_en_o, !we);
        chk(data_oe_o == we, "R7", "data_oe", data_oe_o, we);
        chk(byte_en_o == (we ? 4'hF : 4'h0), "R7", "byte_en", byte_en_o, we ? 4'hF : 4'h0);
        if (we) chk(data_o == wl[bidx*32 +: 32], "R7", "write lane", data_o, wl[bidx*32 +: 32]);
        if (wcnt == wt) begin
          ta_i = 1'b1;
          data_i = rl[bidx*32 +: 32];
          adv = 1'b1;
        end else begin
          ta_i = 1'b0;
          data_i = 32'h0BAD_0BAD;
          wcnt++;
        end
        if (inject && bidx == 1) begin
          req_i = 1'b1;
          req_addr_i = 32'h2000_0000;
          req_we_i = !we;
        end
      end
      @(negedge clk_i);
      req_i = 1'b0;
      if (adv) begin bidx++; wcnt = 0; end
    end
    ta_i = 1'b0;
    chk(done_o, "R10", "done raised", done_o, 1);
    chk(cyc == exp_cyc, "R9", "busy clocks", cyc, exp_cyc);
    chk(tsc == exp_ts, "R2", "start pulses", tsc, exp_ts);
    chk(!xfer_busy_o, "R2", "busy low at done", xfer_busy_o, 0);
    chk(!cs_o, "R3", "cs released", cs_o, 0);
    chk(bidx == 4, "R5", "beat count", bidx, 4);
    if (!we) chk(rline_o == rl, "R8", "read line", rline_o, rl);
    @(negedge clk_i);
    chk(!done_o, "R10", "done one clock", done_o, 0);
    if (inject) begin
      repeat (2) begin
        chk(!xfer_busy_o && !xfer_start_o, "R1", "request during line ignored", xfer_busy_o, 0);
        @(negedge clk_i);
      end
    end
  endtask

  initial begin
    #1;
    chk(!xfer_busy_o && !cs_o && !xfer_start_o && !done_o, "R2", "reset idle",
        {xfer_busy_o, cs_o, xfer_start_o, done_o}, 0);
    chk(bus_addr_o == 0 && byte_en_o == 0 && !out_en_o && !data_oe_o, "R7", "reset bus outputs",
        {bus_addr_o, byte_en_o, out_en_o, data_oe_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_line(i, VEC[i][13], VEC[i][12], VEC[i][11], int'(VEC[i][10:9]), VEC[i][8],
               int'(VEC[i][7:3]), int'(VEC[i][2:0]), 1'b0);
    end

    // R4: acknowledge while idle starts nothing
    @(negedge clk_i);
    ta_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!xfer_busy_o && !done_o, "R4", "idle ack ignored", xfer_busy_o, 0);
    ta_i = 1'b0;

    // R1: request raised mid-line is dropped
    run_line(9, 1'b0, 1'b1, 1'b1, 0, 1'b0, 5, 1, 1'b1);
    run_line(10, 1'b1, 1'b0, 1'b0, 1, 1'b0, 12, 4, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule